// File: doc/BRIEF.md
# Vector Single-to-Half Narrowing Converter

The block turns a 128-bit vector holding four single-precision floating-point numbers into four half-precision numbers. Each conversion rounds according to a 2-bit mode chosen at run time. The four 16-bit results are packed into a 64-bit group. A half-select input then places that group either in the low half of a fresh 128-bit destination, with the high half cleared, or in the high half, with the low half taken unchanged from the old destination value.

The conversion logic is combinational. A single register stage captures the destination when the start strobe is high and raises the valid strobe on the following cycle. Four sticky status flags collect the floating-point exceptions of every element. They keep their state until an explicit clear input is applied.

Top module: `fp_narrow_vec`

## Requirements
- R1: Source element i (bits [32i+31:32i]) converts to result element i, which sits at bits [16i+15:16i] of the packed 64-bit group, for i = 0..3.
- R2: With `upper_i` = 0 the packed group lands on `dst_o[63:0]` and `dst_o[127:64]` is zero.
- R3: With `upper_i` = 1 the packed group lands on `dst_o[127:64]` and `dst_o[63:0]` equals `old_dst_i[63:0]` as sampled with the start strobe.
- R4: `rmode_i` selects the rounding applied to all four elements: 00 nearest with ties to even, 01 toward +infinity, 10 toward -infinity, 11 toward zero.
- R5: A finite result too large for half precision becomes infinity or the largest finite value (0x7BFF magnitude), chosen by mode and sign, and sets both the overflow and inexact flags.
- R6: Results below the half normal range are correctly rounded subnormals or zero. A result counts as tiny when the exact value is below 2^-14 before rounding, and underflow is set only when the result is tiny and inexact.
- R7: A signalling NaN input (mantissa bit 22 clear) gives a quiet NaN with the same sign, exponent all ones, mantissa bit 9 set and mantissa bits [8:0] copied from source bits [21:13], and sets invalid. A quiet NaN gives the same encoding without setting invalid.
- R8: Infinities and signed zeros convert exactly and raise no flag.
- R9: `flags_o` bit 3 is invalid, bit 2 overflow, bit 1 underflow, bit 0 inexact. On a start the flags become the OR of the four element flags with the held flags. `flag_clr_i` zeroes the held flags first, and a start in the same cycle ORs its flags onto zero. With neither input high the flags hold.
- R10: `valid_o` is high in exactly the cycle after each cycle in which `start_i` was high. `dst_o` changes only on the edge that captures a start.
- R11: After reset, `dst_o`, `valid_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one conversion this cycle |
| upper_i | input | 1 | 0: low-half placement with high half cleared; 1: high-half placement keeping the low half |
| rmode_i | input | 2 | Rounding mode select |
| flag_clr_i | input | 1 | Clear the sticky flags |
| src_i | input | 128 | Four single-precision source elements |
| old_dst_i | input | 128 | Previous destination value |
| dst_o | output | 128 | New destination value |
| valid_o | output | 1 | Result strobe, one cycle after start |
| flags_o | output | 4 | Sticky flags {invalid, overflow, underflow, inexact} |

## Verification
The bench builds the block with its default parameters: four lanes, an 8-bit exponent with a 23-bit mantissa in, and a 5-bit exponent with a 10-bit mantissa out. At these widths every half exponent can be reached, including the carry from rounding that pushes exponent 30 into overflow. Single-precision inputs that sit just below the half normal range, deep in the subnormal range, or are themselves subnormal exercise the right-shift clamp and the folding of shifted-out bits into the sticky bit. All four rounding modes run on ties, on odd and even neighbours and on both signs. This exposes each branch of the increment logic and each overflow choice between infinity and the largest finite value.

// File: rtl/fpn_pkg.sv
`timescale 1ns/1ps
package fpn_pkg;

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'b00,
      RM_TO_POS    = 2'b01,
      RM_TO_NEG    = 2'b10,
      RM_TO_ZERO   = 2'b11
   } rmode_e;

   typedef struct packed {
      logic nv;   // invalid operation
      logic of;   // overflow
      logic uf;   // underflow
      logic nx;   // inexact
   } fflags_t;

   localparam int FLAG_W = 4;

endpackage

// File: rtl/fpn_lane.sv
`timescale 1ns/1ps
module fpn_lane
   import fpn_pkg::*;
#(
   parameter int SE = 8,
   parameter int SM = 23,
   parameter int DE = 5,
   parameter int DM = 10
) (
   input  logic [SE+SM:0] a_i,
   input  rmode_e         rm_i,
   output logic [DE+DM:0] h_o,
   output fflags_t        fl_o
);

   localparam int SW     = 1 + SE + SM;
   localparam int SBIAS  = (1 << (SE - 1)) - 1;
   localparam int DBIAS  = (1 << (DE - 1)) - 1;
   localparam int BDIFF  = SBIAS - DBIAS;
   localparam int TW     = SE + 2;
   localparam int SH_CAP = SM + 3;
   localparam int SHW    = $clog2(SH_CAP + 1);
   localparam int WW     = SM + 1 + SH_CAP;
   localparam int CW     = DE + DM;
   localparam int EMAX   = (1 << DE) - 1;

   generate
      if (DE >= SE || DM >= SM) begin : g_bad_fmt
         $error("fpn_lane: destination format must be narrower than source");
      end
      if (DM < 2) begin : g_bad_man
         $error("fpn_lane: destination mantissa too short for NaN payload");
      end
   endgenerate

   logic                 sgn;
   logic [SE-1:0]        ex;
   logic [SM-1:0]        mn;
   logic                 is_max_e, is_zero_e, mn_nz;
   logic [SM:0]          sig;
   logic [SE-1:0]        eff_e;
   logic signed [TW-1:0] te, sh_raw;
   logic                 normal_in, big;
   logic [SHW-1:0]       sh;
   logic [WW-1:0]        wide;
   logic [DM:0]          kept;
   logic                 grd, stk, rnd_any, inc;
   logic [DE-1:0]        exp_f;
   logic [CW-1:0]        comb;
   logic                 ovf, tiny, to_inf;

   assign sgn       = a_i[SW-1];
   assign ex        = a_i[SW-2:SM];
   assign mn        = a_i[SM-1:0];
   assign is_max_e  = &ex;
   assign is_zero_e = ~|ex;
   assign mn_nz     = |mn;
   assign sig       = {~is_zero_e, mn};
   assign eff_e     = is_zero_e ? SE'(1) : ex;

   // destination-relative biased exponent before rounding
   assign te        = $signed({2'b00, eff_e}) - $signed(TW'(BDIFF));
   assign sh_raw    = $signed(TW'(1)) - te;
   assign normal_in = te > $signed(TW'(0));
   assign big       = te >= $signed(TW'(EMAX));

   always_comb begin
      if (normal_in)                          sh = '0;
      else if (sh_raw > $signed(TW'(SH_CAP))) sh = SHW'(SH_CAP);
      else                                    sh = sh_raw[SHW-1:0];
   end

   // alignment shifter; bits pushed below the guard feed the sticky bit
   assign wide    = {sig, {SH_CAP{1'b0}}} >> sh;
   assign kept    = wide[WW-1 -: DM+1];
   assign grd     = wide[WW-DM-2];
   assign stk     = |wide[WW-DM-3:0];
   assign rnd_any = grd | stk;

   always_comb begin
      case (rm_i)
         RM_NEAR_EVEN: inc = grd & (stk | kept[0]);
         RM_TO_POS:    inc = ~sgn & rnd_any;
         RM_TO_NEG:    inc = sgn & rnd_any;
         default:      inc = 1'b0;
      endcase
   end

   // exponent and mantissa are added as one field so a mantissa carry
   // lifts the exponent (and turns a subnormal into the minimum normal)
   assign exp_f  = kept[DM] ? te[DE-1:0] : '0;
   assign comb   = {exp_f, kept[DM-1:0]} + CW'(inc);
   assign ovf    = big | (&comb[CW-1:DM]);
   assign tiny   = ~normal_in;
   assign to_inf = (rm_i == RM_NEAR_EVEN) |
                   ((rm_i == RM_TO_POS) & ~sgn) |
                   ((rm_i == RM_TO_NEG) & sgn);

   always_comb begin
      h_o  = '0;
      fl_o = '0;
      if (is_max_e) begin
         if (mn_nz) begin
            h_o     = {sgn, {DE{1'b1}}, 1'b1, mn[SM-2 -: DM-1]};
            fl_o.nv = ~mn[SM-1];
         end else begin
            h_o = {sgn, {DE{1'b1}}, {DM{1'b0}}};
         end
      end else if (is_zero_e & ~mn_nz) begin
         h_o = {sgn, {CW{1'b0}}};
      end else if (ovf) begin
         h_o     = to_inf ? {sgn, {DE{1'b1}}, {DM{1'b0}}}
                          : {sgn, {(DE-1){1'b1}}, 1'b0, {DM{1'b1}}};
         fl_o.of = 1'b1;
         fl_o.nx = 1'b1;
      end else begin
         h_o     = {sgn, comb};
         fl_o.nx = rnd_any;
         fl_o.uf = tiny & rnd_any;
      end
   end

endmodule

// File: rtl/fpn_merge.sv
`timescale 1ns/1ps
module fpn_merge #(
   parameter int GRP_W = 64
) (
   input  logic                 upper_i,
   input  logic [GRP_W-1:0]     grp_i,
   input  logic [2*GRP_W-1:0]   old_i,
   output logic [2*GRP_W-1:0]   dst_o
);

   generate
      if (GRP_W < 1) begin : g_bad_w
         $error("fpn_merge: group width must be positive");
      end
   endgenerate

   always_comb begin
      if (upper_i) dst_o = {grp_i, old_i[GRP_W-1:0]};
      else         dst_o = {{GRP_W{1'b0}}, grp_i};
   end

endmodule

// File: rtl/fpn_sticky.sv
`timescale 1ns/1ps
module fpn_sticky
   import fpn_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    clr_i,
   input  logic [LANES*FLAG_W-1:0] lane_fl_i,
   output logic [FLAG_W-1:0]       flags_o
);

   logic [FLAG_W-1:0] new_fl;
   logic [FLAG_W-1:0] base_fl;

   always_comb begin
      new_fl = '0;
      for (int l = 0; l < LANES; l++) begin
         new_fl = new_fl | lane_fl_i[l*FLAG_W +: FLAG_W];
      end
   end

   assign base_fl = clr_i ? '0 : flags_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags_o <= '0;
      else if (start_i) flags_o <= base_fl | new_fl;
      else              flags_o <= base_fl;
   end

endmodule

// File: rtl/fp_narrow_vec.sv
`timescale 1ns/1ps
module fp_narrow_vec
   import fpn_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int SRC_EXP = 8,
   parameter int SRC_MAN = 23,
   parameter int DST_EXP = 5,
   parameter int DST_MAN = 10
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  start_i,
   input  logic                                  upper_i,
   input  logic [1:0]                            rmode_i,
   input  logic                                  flag_clr_i,
   input  logic [LANES*(1+SRC_EXP+SRC_MAN)-1:0]  src_i,
   input  logic [LANES*(1+SRC_EXP+SRC_MAN)-1:0]  old_dst_i,
   output logic [LANES*(1+SRC_EXP+SRC_MAN)-1:0]  dst_o,
   output logic                                  valid_o,
   output logic [3:0]                            flags_o
);

   localparam int SRC_W = 1 + SRC_EXP + SRC_MAN;
   localparam int DST_W = 1 + DST_EXP + DST_MAN;
   localparam int VEC_W = LANES * SRC_W;
   localparam int GRP_W = LANES * DST_W;
   localparam int FL_W  = LANES * FLAG_W;

   generate
      if (SRC_W != 2 * DST_W) begin : g_bad_ratio
         $error("fp_narrow_vec: source element must be twice the result width");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("fp_narrow_vec: at least one lane required");
      end
   endgenerate

   rmode_e           rm;
   logic [GRP_W-1:0] grp;
   logic [FL_W-1:0]  lane_fl;
   logic [VEC_W-1:0] merged;

   assign rm = rmode_e'(rmode_i);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         fflags_t fl_g;
         fpn_lane #(
            .SE (SRC_EXP),
            .SM (SRC_MAN),
            .DE (DST_EXP),
            .DM (DST_MAN)
         ) u_lane (
            .a_i  (src_i[g*SRC_W +: SRC_W]),
            .rm_i (rm),
            .h_o  (grp[g*DST_W +: DST_W]),
            .fl_o (fl_g)
         );
         assign lane_fl[g*FLAG_W +: FLAG_W] = fl_g;
      end
   endgenerate

   fpn_merge #(.GRP_W(GRP_W)) u_merge (
      .upper_i (upper_i),
      .grp_i   (grp),
      .old_i   (old_dst_i),
      .dst_o   (merged)
   );

   fpn_sticky #(.LANES(LANES)) u_sticky (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .clr_i     (flag_clr_i),
      .lane_fl_i (lane_fl),
      .flags_o   (flags_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_o   <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= start_i;
         if (start_i) dst_o <= merged;
      end
   end

endmodule

// File: rtl/fpn_checker.sv
`timescale 1ns/1ps
module fpn_checker #(
   parameter int VEC_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             upper_i,
   input logic             flag_clr_i,
   input logic [VEC_W-1:0] old_dst_i,
   input logic [VEC_W-1:0] dst_o,
   input logic             valid_o,
   input logic [3:0]       flags_o
);

   localparam int HW = VEC_W / 2;

   p_valid_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o);

   p_no_stray_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !valid_o);

   p_dst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(dst_o));

   p_low_form_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !upper_i) |=> (dst_o[VEC_W-1:HW] == '0));

   p_high_form_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && upper_i) |=> (dst_o[HW-1:0] == $past(old_dst_i[HW-1:0])));

   p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

   p_flags_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !flag_clr_i) |=> $stable(flags_o));

   p_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !start_i) |=> (flags_o == 4'b0000));

   p_of_with_nx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[2] |-> flags_o[0]);

   p_uf_with_nx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[1] |-> flags_o[0]);

endmodule

bind fp_narrow_vec fpn_checker #(.VEC_W(VEC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .upper_i    (upper_i),
   .flag_clr_i (flag_clr_i),
   .old_dst_i  (old_dst_i),
   .dst_o      (dst_o),
   .valid_o    (valid_o),
   .flags_o    (flags_o)
);

// File: tb/sim_fp_narrow_vec.sv
`timescale 1ns/1ps
module sim_fp_narrow_vec;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         upper_i = 1'b0;
   logic [1:0]   rmode_i = 2'b00;
   logic         flag_clr_i = 1'b0;
   logic [127:0] src_i = '0;
   logic [127:0] old_dst_i = '0;
   logic [127:0] dst_o;
   logic         valid_o;
   logic [3:0]   flags_o;

   always #4 clk = ~clk;

   fp_narrow_vec u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .upper_i    (upper_i),
      .rmode_i    (rmode_i),
      .flag_clr_i (flag_clr_i),
      .src_i      (src_i),
      .old_dst_i  (old_dst_i),
      .dst_o      (dst_o),
      .valid_o    (valid_o),
      .flags_o    (flags_o)
   );

   typedef struct {
      logic [127:0] dst;
      logic [3:0]   fl;
      string        req;
   } item_t;

   item_t        sb_q[$];
   int           n_run = 0;
   int           n_fail = 0;
   bit           done = 1'b0;
   logic [127:0] last_dst = '0;
   logic [3:0]   fl_model = '0;
   logic [31:0]  rs = 32'h1234_5679;

   task automatic check(input bit ok, input string req,
                        input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference: exact value scaled so one unit is the smallest half subnormal
   // (2^-24), carried with 32 extra fraction bits, then rounded to its quantum
   function automatic logic [19:0] ref_cvt(input logic [31:0] x, input logic [1:0] rm);
      logic        s;
      logic [7:0]  e;
      logic [22:0] m;
      logic [23:0] sig;
      logic [95:0] xv, qv, rem, halfq;
      int          ee, p, k, qs, hv;
      bit          nx, up, toinf;
      s = x[31]; e = x[30:23]; m = x[22:0];
      toinf = (rm == 2'b00) || (rm == 2'b01 && !s) || (rm == 2'b10 && s);
      if (e == 8'hFF) begin
         if (m == 0) return {4'b0000, s, 15'h7C00};
         return {~m[22], 3'b000, s, 5'h1F, 1'b1, m[21:13]};
      end
      if (e == 0 && m == 0) return {4'b0000, s, 15'h0000};
      sig = {(e != 0), m};
      ee  = (e == 0) ? 1 : int'(e);
      p   = ee - 126;
      if (p > 16) return {4'b0101, s, toinf ? 15'h7C00 : 15'h7BFF};
      if (p + 32 >= 0) xv = {72'b0, sig} << (p + 32);
      else             xv = 96'd1;
      k = 0;
      for (int i = 0; i < 96; i++) if (xv[i]) k = i - 32;
      qs    = 32 + ((k > 10) ? (k - 10) : 0);
      qv    = xv >> qs;
      rem   = xv & ((96'd1 << qs) - 96'd1);
      halfq = 96'd1 << (qs - 1);
      nx    = (rem != 0);
      case (rm)
         2'b00:   up = (rem > halfq) || (rem == halfq && qv[0]);
         2'b01:   up = !s && nx;
         2'b10:   up = s && nx;
         default: up = 1'b0;
      endcase
      hv = (((k > 10) ? (k - 10) : 0) << 10) + int'(qv[11:0]) + int'(up);
      if (hv >= 32'h7C00) return {4'b0101, s, toinf ? 15'h7C00 : 15'h7BFF};
      return {1'b0, 1'b0, (k < 10) && nx, nx, s, hv[14:0]};
   endfunction

   // driver: called at a falling edge, holds start for one cycle
   task automatic drive(input logic [127:0] src, input logic [127:0] old,
                        input logic up, input logic [1:0] rm,
                        input logic clr, input string req);
      item_t       it;
      logic [63:0] pk;
      logic [3:0]  nf;
      logic [19:0] r;
      nf = '0;
      for (int i = 0; i < 4; i++) begin
         r = ref_cvt(src[32*i +: 32], rm);
         pk[16*i +: 16] = r[15:0];
         nf = nf | r[19:16];
      end
      it.dst   = up ? {pk, old[63:0]} : {64'b0, pk};
      fl_model = (clr ? 4'b0000 : fl_model) | nf;
      it.fl    = fl_model;
      it.req   = req;
      sb_q.push_back(it);
      src_i = src; old_dst_i = old; upper_i = up; rmode_i = rm;
      flag_clr_i = clr; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; flag_clr_i = 1'b0;
   endtask

   task automatic clear_only();
      flag_clr_i = 1'b1;
      @(negedge clk);
      flag_clr_i = 1'b0;
      fl_model = '0;
      check(flags_o == 4'b0000, "R9 clear without start", 128'(flags_o), 128'h0);
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] v);
      logic [31:0] t;
      t = v ^ (v << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   // monitor: samples 2 ns after the rising edge
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         if (valid_o) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R10 valid without start", 128'(valid_o), 128'h0);
            end else begin
               item_t it;
               it = sb_q.pop_front();
               check(dst_o === it.dst, it.req, dst_o, it.dst);
               check(flags_o === it.fl, {it.req, " R9 flags"}, 128'(flags_o), 128'(it.fl));
               last_dst = it.dst;
            end
         end else begin
            if (sb_q.size() != 0) check(1'b0, "R10 valid missing", 128'h0, 128'h1);
            check(dst_o === last_dst, "R10 hold while idle", dst_o, last_dst);
         end
      end
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(dst_o == '0, "R11 reset dst", dst_o, 128'h0);
      check(valid_o == 1'b0, "R11 reset valid", 128'(valid_o), 128'h0);
      check(flags_o == 4'b0, "R11 reset flags", 128'(flags_o), 128'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2: element order and low-half placement, nearest-even
      drive({32'h3EAA_AAAB, 32'h477F_E000, 32'hC000_0000, 32'h3F80_0000},
            {4{32'hA5A5_5A5A}}, 1'b0, 2'b00, 1'b0, "R1 R2 low pack");
      check(dst_o[63:0] == 64'h3555_7BFF_C000_3C00, "R1 lane constants",
            128'(dst_o[63:0]), 128'h3555_7BFF_C000_3C00);

      // R3: high-half placement keeps the old low half
      drive({32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, 32'hBF80_0000},
            {64'h1111_2222_3333_4444, 64'hDEAD_BEEF_0BAD_F00D}, 1'b1, 2'b00, 1'b0,
            "R3 high pack");
      check(dst_o[63:0] == 64'hDEAD_BEEF_0BAD_F00D, "R3 low half kept",
            128'(dst_o[63:0]), 128'hDEAD_BEEF_0BAD_F00D);

      // R4: ties, odd/even neighbours, both signs, every mode
      for (int md = 0; md < 4; md++) begin
         drive({32'h3F80_1001, 32'hBF80_1000, 32'h3F80_3000, 32'h3F80_1000},
               '0, 1'b0, 2'(md), 1'b1, "R4 rounding modes");
      end

      // R5: overflow boundary in every mode
      for (int md = 0; md < 4; md++) begin
         drive({32'h477F_E000, 32'h7F00_0000, 32'hC77F_F000, 32'h477F_F000},
               '0, md[0], 2'(md), 1'b1, "R5 overflow");
      end

      // R6: subnormal range, halfway tie at 2^-25, source subnormal
      for (int md = 0; md < 4; md++) begin
         drive({32'h8000_0001, 32'h387F_E000, 32'h3300_0000, 32'h3380_0000},
               '0, 1'b0, 2'(md), 1'b1, "R6 subnormal");
         drive({32'h3880_0000, 32'h387F_F000, 32'hB3C0_0000, 32'h0040_0000},
               '0, 1'b0, 2'(md), 1'b1, "R6 near min normal");
      end

      // R7: NaN handling; R8: exact specials with flags cleared first
      drive({32'h7FC0_2000, 32'hFFA0_4000, 32'h7FC0_1234, 32'h7F80_0001},
            '0, 1'b0, 2'b00, 1'b1, "R7 nan");
      drive({32'h7FC0_0000, 32'hFFE0_0000, 32'h7FC0_0000, 32'h7FFF_E000},
            '0, 1'b0, 2'b11, 1'b1, "R7 quiet nan no invalid");
      drive({32'h8000_0000, 32'h0000_0000, 32'hFF80_0000, 32'h7F80_0000},
            '0, 1'b0, 2'b01, 1'b1, "R8 specials exact");

      // R9: accumulate, clear without start, then idle hold
      drive({4{32'h3F80_1000}}, '0, 1'b0, 2'b00, 1'b0, "R9 accumulate nx");
      drive({4{32'h7F80_0001}}, '0, 1'b0, 2'b00, 1'b0, "R9 accumulate nv");
      @(negedge clk);
      clear_only();
      @(negedge clk);
      check(flags_o == 4'b0000, "R9 flags stay clear", 128'(flags_o), 128'h0);
      drive({4{32'h3F80_0000}}, '0, 1'b0, 2'b00, 1'b1, "R9 clear with exact start");

      // R10 and mixed coverage: back-to-back and gapped random operations
      for (int n = 0; n < 80; n++) begin
         logic [127:0] s, o;
         for (int l = 0; l < 4; l++) begin
            rs = nxt(rs);
            s[32*l +: 32] = {rs[31], 8'(8'd96 + 8'(rs[30:23] % 8'd52)), rs[22:0]};
            if (rs[7:0] == 8'h00) s[32*l + 23 +: 8] = 8'hFF;
            if (rs[7:0] == 8'h01) s[32*l + 23 +: 8] = 8'h00;
            rs = nxt(rs);
            o[32*l +: 32] = rs;
         end
         rs = nxt(rs);
         drive(s, o, rs[0], rs[2:1], rs[5:3] == 3'b000, "R1 R4 R10 random");
         if (rs[9:8] == 2'b00) repeat (int'(rs[11:10]) + 1) @(negedge clk);
      end

      repeat (4) @(negedge clk);
      check(sb_q.size() == 0, "R10 all results seen", 128'(sb_q.size()), 128'h0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule